// File: doc/BRIEF.md
# PWM Time-Base Counter with Prescaler

This block is the timing core of a two-channel pulse-width modulator. A programmable two-stage divider slows the input clock down to a counting tick. On each tick a 16-bit counter steps according to a selectable mode: it can count upward, count downward, count up and then back down, or hold its value. One period register bounds the counter for both channels. Each channel has its own compare register.

Four event strobes tell downstream output logic where the counter stands: it is at zero, it is at the period, or it matches compare A or compare B while counting upward. Software programs the block through a small synchronous write port. The period can be loaded at once, or staged in a shadow copy that takes effect only when the counter next reaches zero. Staging keeps a running waveform glitch-free.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous reset clears the counter, the prescaler, the control fields, both compare registers and both period copies to 0. After reset the counter is in up mode with a period of 0, so `count` is 0 and all four strobes are 1.
- R2: The write port decodes `wrAddr` as follows: 0 is control, 1 is period, 2 is compare A and 3 is compare B. Control bits 12:10 hold field `a` and bits 9:7 hold field `b`. The counter steps once every 2^a × (b==0 ? 1 : 2b) clocks.
- R3: In up mode (control bits 1:0 = 00), each tick increments the counter. A tick taken at or above the active period sets it to 0 instead. This includes a period of 0xFFFF.
- R4: In down mode (bits 1:0 = 01), each tick decrements the counter. A tick taken at 0 reloads the active period.
- R5: In up-down mode (bits 1:0 = 10), the counter rises to the active period and then falls back to 0, reversing direction at each end. A period of 0 holds it at 0.
- R6: In freeze mode (bits 1:0 = 11), the counter holds its value regardless of ticks.
- R7: With control bit 3 at 0, a period write goes only to the shadow copy. The shadow copy moves to the active period on a tick that takes the counter to 0. Until then the counter keeps using the old active period.
- R8: With control bit 3 at 1, a period write updates the active period at once, starting from the next clock.
- R9: `evZero` is 1 while the counter equals 0, and `evPeriod` is 1 while it equals the active period. Each therefore lasts one tick of the counter. In freeze mode all four strobes are 0.
- R10: `evCmpAUp` (compare A) and `evCmpBUp` (compare B) are 1 while the counter equals that channel's compare value and is moving upward. Moving upward means up mode, or the rising half of up-down mode. They are never 1 in down mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 period, 2 compare A, 3 compare B |
| wrData | input | 16 | Write data |
| count | output | 16 | Current counter value |
| evZero | output | 1 | Counter is at zero |
| evPeriod | output | 1 | Counter is at the active period |
| evCmpAUp | output | 1 | Counter matches compare A while rising |
| evCmpBUp | output | 1 | Counter matches compare B while rising |

## Verification
The assertions assume that the write port carries at most one write per clock. They also assume that a period change can make the counter exceed the active period, and they are phrased so that such an overshoot does not trip them. The bench writes each register with a one-cycle strobe. It shrinks the period while the counter runs above the new value, and it switches counting modes in mid-count, so direction and wrap handling are exercised outside the steady state. A behavioural model tracks the counter, the direction and both period copies on every clock. Each output is compared against it at the falling edge.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_FREEZE = 2'b11
  } cntMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     tick;
    logic     prdWr;
    logic     prdImm;
    cntMode_e mode;
  } tbStrobe_t;

  localparam int MODE_LSB   = 0;
  localparam int LOAD_BIT   = 3;
  localparam int HSP_LSB    = 7;
  localparam int CLKDIV_LSB = 10;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRD  = 2'd1;
  localparam logic [1:0] ADDR_CMPA = 2'd2;
  localparam logic [1:0] ADDR_CMPB = 2'd3;

endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CD_W  = 3,
  parameter int HS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output tbStrobe_t        strb,
  output logic [CNT_W-1:0] cmpA,
  output logic [CNT_W-1:0] cmpB
);

  // widest ratio: 2^(2^CD_W-1) * 2*(2^HS_W-1)
  localparam int PRE_W = (2 ** CD_W - 1) + HS_W + 1;

  cntMode_e         mode;
  logic             prdImm;
  logic [HS_W-1:0]  hsDiv;
  logic [CD_W-1:0]  cdDiv;
  logic [PRE_W-1:0] preCnt;
  logic [HS_W:0]    hsFactor;
  logic [PRE_W-1:0] ratio;
  logic             tick;
  logic             ctlWr;

  assign hsFactor = (hsDiv == '0) ? (HS_W+1)'(1) : {hsDiv, 1'b0};
  assign ratio    = PRE_W'(hsFactor) << cdDiv;
  assign tick     = (preCnt >= ratio - 1'b1);
  assign ctlWr    = wrEn && (wrAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= CM_UP;
      prdImm <= 1'b0;
      hsDiv  <= '0;
      cdDiv  <= '0;
      cmpA   <= '0;
      cmpB   <= '0;
      preCnt <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (wrEn) begin
        case (wrAddr)
          ADDR_CTRL: begin
            mode   <= cntMode_e'(wrData[MODE_LSB +: 2]);
            prdImm <= wrData[LOAD_BIT];
            hsDiv  <= wrData[HSP_LSB +: HS_W];
            cdDiv  <= wrData[CLKDIV_LSB +: CD_W];
          end
          ADDR_CMPA: cmpA <= wrData;
          ADDR_CMPB: cmpB <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb        = '0;
    strb.tick   = tick;
    strb.prdWr  = wrEn && (wrAddr == ADDR_PRD);
    strb.prdImm = prdImm;
    strb.mode   = mode;
  end

  // R2: with an unchanged ratio above one, ticks never fall on adjacent clocks
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctlWr && ratio > 1) |=> !tick);

endmodule

// File: rtl/pwm_tb_dp.sv
module pwm_tb_dp
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  tbStrobe_t                  strb,
  input  logic [CNT_W-1:0]           wrData,
  input  logic [N_CH-1:0][CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0]           count,
  output logic                       evZero,
  output logic                       evPeriod,
  output logic [N_CH-1:0]            evCmpUp
);

  logic [CNT_W-1:0] cnt, actPrd, shdPrd, nextCnt;
  logic             dirUp, nextDir, stepEn, frozen, rising;

  assign frozen = (strb.mode == CM_FREEZE);
  assign stepEn = strb.tick && !frozen;

  always_comb begin
    nextCnt = cnt;
    nextDir = dirUp;
    case (strb.mode)
      CM_UP: begin
        nextDir = 1'b1;
        nextCnt = (cnt >= actPrd) ? '0 : cnt + 1'b1;
      end
      CM_DOWN: begin
        nextDir = 1'b0;
        nextCnt = (cnt == '0) ? actPrd : cnt - 1'b1;
      end
      CM_UPDOWN: begin
        if (actPrd == '0) begin
          nextCnt = '0;
          nextDir = 1'b1;
        end else if (dirUp) begin
          if (cnt >= actPrd) begin
            nextCnt = cnt - 1'b1;
            nextDir = 1'b0;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          nextCnt = CNT_W'(1);
          nextDir = 1'b1;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dirUp  <= 1'b1;
      actPrd <= '0;
      shdPrd <= '0;
    end else begin
      if (stepEn) begin
        cnt   <= nextCnt;
        dirUp <= nextDir;
      end
      if (stepEn && nextCnt == '0 && !strb.prdImm)
        actPrd <= shdPrd;
      if (strb.prdWr) begin
        shdPrd <= wrData;
        if (strb.prdImm)
          actPrd <= wrData;
      end
    end
  end

  assign rising   = (strb.mode == CM_UP) || (strb.mode == CM_UPDOWN && dirUp);
  assign count    = cnt;
  assign evZero   = !frozen && (cnt == '0);
  assign evPeriod = !frozen && (cnt == actPrd);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_cmp
    assign evCmpUp[ch] = !frozen && rising && (cnt == cmpVal[ch]);
  end

  // R3: an up-mode tick below the period advances by exactly one
  a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && strb.mode == CM_UP && cnt < actPrd)
      |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R4: a down-mode tick at zero reloads the active period
  a_r4_down_reload: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && strb.mode == CM_DOWN && cnt == '0) |=> cnt == $past(actPrd));

  // R6: freeze holds the counter
  a_r6_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.mode == CM_FREEZE) |=> $stable(cnt));

  // R7: without a counting tick or an immediate write, the active period holds
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (!stepEn && !(strb.prdWr && strb.prdImm)) |=> $stable(actPrd));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             evZero,
  output logic             evPeriod,
  output logic             evCmpAUp,
  output logic             evCmpBUp
);

  localparam int N_CH = 2;

  tbStrobe_t                  strb;
  logic [CNT_W-1:0]           cmpA, cmpB;
  logic [N_CH-1:0][CNT_W-1:0] cmpVal;
  logic [N_CH-1:0]            evCmpUp;

  assign cmpVal   = {cmpB, cmpA};
  assign evCmpAUp = evCmpUp[0];
  assign evCmpBUp = evCmpUp[1];

  pwm_tb_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .cmpA(cmpA), .cmpB(cmpB)
  );

  pwm_tb_dp #(.CNT_W(CNT_W), .N_CH(N_CH)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .cmpVal(cmpVal),
    .count(count), .evZero(evZero), .evPeriod(evPeriod), .evCmpUp(evCmpUp)
  );

endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic        evZero, evPeriod, evCmpAUp, evCmpBUp;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural model state
  int mCnt, mDir, mAct, mShd, mCa, mCb, mMode, mImm, mCd, mHs, mPre;

  always #5 clk = ~clk;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .evZero(evZero), .evPeriod(evPeriod),
    .evCmpAUp(evCmpAUp), .evCmpBUp(evCmpBUp)
  );

  always @(posedge clk) begin
    int ratio, nCnt, nDir;
    bit tick;
    if (rst) begin
      mCnt = 0; mDir = 1; mAct = 0; mShd = 0; mCa = 0; mCb = 0;
      mMode = 0; mImm = 0; mCd = 0; mHs = 0; mPre = 0;
    end else begin
      ratio = (1 << mCd) * ((mHs == 0) ? 1 : 2 * mHs);
      tick  = (mPre >= ratio - 1);
      mPre  = tick ? 0 : mPre + 1;
      if (tick && mMode != 3) begin
        nCnt = mCnt; nDir = mDir;
        if (mMode == 0) begin
          nDir = 1; nCnt = (mCnt >= mAct) ? 0 : mCnt + 1;
        end else if (mMode == 1) begin
          nDir = 0; nCnt = (mCnt == 0) ? mAct : mCnt - 1;
        end else if (mAct == 0) begin
          nCnt = 0; nDir = 1;
        end else if (mDir == 1) begin
          if (mCnt >= mAct) begin nCnt = mCnt - 1; nDir = 0; end
          else nCnt = mCnt + 1;
        end else if (mCnt == 0) begin
          nCnt = 1; nDir = 1;
        end else nCnt = mCnt - 1;
        if (nCnt == 0 && mImm == 0) mAct = mShd;
        mCnt = nCnt; mDir = nDir;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin
            mMode = wrData[1:0]; mImm = wrData[3];
            mHs = wrData[9:7]; mCd = wrData[12:10];
          end
          2'd1: begin mShd = wrData; if (mImm) mAct = wrData; end
          2'd2: mCa = wrData;
          default: mCb = wrData;
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    bit fr, ez, ep, ea, eb, rising;
    cycles++;
    if (!rst) begin
      fr = (mMode == 3);
      rising = (mMode == 0) || (mMode == 2 && mDir == 1);
      ez = !fr && mCnt == 0;
      ep = !fr && mCnt == mAct;
      ea = !fr && rising && mCnt == mCa;
      eb = !fr && rising && mCnt == mCb;
      total++;
      if (count !== 16'(mCnt) || evZero !== ez || evPeriod !== ep ||
          evCmpAUp !== ea || evCmpBUp !== eb) begin
        bad++;
        $display("FAIL %s: cnt=%0d z=%b p=%b a=%b b=%b exp cnt=%0d z=%b p=%b a=%b b=%b",
                 curReq, count, evZero, evPeriod, evCmpAUp, evCmpBUp,
                 mCnt, ez, ep, ea, eb);
      end
    end
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, period 0 and compares 0 in up mode
    @(negedge clk);
    chk("R1", count, 16'd0);
    chk("R1", {12'd0, evZero, evPeriod, evCmpAUp, evCmpBUp}, 16'hF);

    // R8: immediate period load, up mode, ratio 1
    curReq = "R8";
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd3);
    wr(2'd3, 16'd7);
    curReq = "R3";
    run(40);
    // R8: shrink below the running count, immediate
    curReq = "R8";
    wr(2'd1, 16'd4);
    run(20);
    wr(2'd1, 16'd9);

    // R2: ratio 2*6 = 12, then 4, then 1*2 = 2
    curReq = "R2";
    wr(2'd0, 16'h0588);
    run(300);
    wr(2'd0, 16'h0808);
    run(100);
    wr(2'd0, 16'h0088);
    run(60);

    // R4: down mode
    curReq = "R4";
    wr(2'd0, 16'h0009);
    run(40);

    // R5 / R10: up-down mode, compares on rising half only
    curReq = "R5";
    wr(2'd0, 16'h000A);
    run(60);
    curReq = "R10";
    wr(2'd2, 16'd0);
    wr(2'd3, 16'd9);
    run(40);

    // R6 / R9: freeze, strobes off
    curReq = "R6";
    wr(2'd0, 16'h000B);
    run(20);
    chk("R9", {13'd0, evZero, evPeriod, evCmpAUp}, 16'd0);

    // R7: shadow load in up mode
    curReq = "R7";
    wr(2'd0, 16'h0000);
    run(3);
    wr(2'd1, 16'd5);
    run(30);
    wr(2'd1, 16'd12);
    run(40);
    // R7: shadow load in up-down and down modes
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'd6);
    run(60);
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd3);
    run(40);

    // R3: full-width period wraps through zero
    curReq = "R3";
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'hFFFE);
    wr(2'd3, 16'h0001);
    run(65600);

    // R1: reset mid-run returns to the cleared state
    curReq = "R1";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", count, 16'd0);
    chk("R1", {12'd0, evZero, evPeriod, evCmpAUp, evCmpBUp}, 16'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule